// File: doc/BRIEF.md
# Per-Timeslot Channel Blocking Strobe

This block steps through the 32 timeslots of an E1 transmit frame and, for each timeslot, drives a blocking strobe taken from a 32-bit per-channel mask. A bit clock enable advances an in-slot bit counter. Every eight bit clocks the counter moves to the next timeslot. A frame sync pulse puts the counter back to the first channel. Software loads the mask one byte at a time through a small write port that holds four byte registers.

A second interpretation of the same four bytes can be selected. In that mode the strobe is held low. Each mask bit then acts as a signaling-source select for one channel, and the bits are interleaved: the even bits of a byte serve four channels from the lower half of the frame, and the odd bits serve four channels from the upper half. The block outputs the full decoded select vector, the source code for the current channel, and a warning when the two channels that must draw signaling from the internal registers are not set that way. A mode request is applied only at a frame boundary, so a frame is never split between the two meanings.

Top module: `tx_chan_blk`

## Requirements
- R1: After reset, all four mask bytes, the slot index, the bit index and the active mode are zero.
- R2: Each cycle with `bit_en` high advances `bit_o`. When `bit_o` is 7, it returns to 0 and `slot_o` advances, wrapping from 31 to 0. When `bit_en` and `fsync` are high together, both indices become 0. When `bit_en` is low, both hold.
- R3: A cycle with `wr_en` high stores `wr_data` in byte `wr_idx`, and the stored value is visible from the next cycle. Byte k bit b is flat mask bit 8k+b, and flat bit n belongs to `slot_o` value n (channel n+1).
- R4: In normal mode (`alt_o`=0), `blk_o` equals the flat mask bit indexed by `slot_o`.
- R5: In alternate mode (`alt_o`=1), `blk_o` is 0 whatever the mask holds.
- R6: In alternate mode, `sel_vec_o[c]` for c<16 is byte c/4 bit 2*(c%4), and for c>=16 it is byte (c-16)/4 bit 2*((c-16)%4)+1.
- R7: In alternate mode, `cur_src_o` is 2 (internal registers) when `sel_vec_o[slot_o]` is 1. Otherwise it is 1 (dedicated signaling input) when `sig_pin_sel` is 1, and 0 (serial data input) when it is 0.
- R8: `cas_warn_o` is 1 exactly when the block is in alternate mode and either `sel_vec_o[0]` or `sel_vec_o[16]` is 0.
- R9: `alt_o` takes the value of `alt_req` only on a frame boundary: a cycle with `bit_en` high and either `fsync` high or `slot_o`=31 with `bit_o`=7. At any other time it holds.
- R10: In normal mode, `sel_vec_o` is all zero, `cur_src_o` is 0 and `cas_warn_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One pulse per transmit bit time |
| fsync | input | 1 | Frame sync, qualified by bit_en |
| wr_en | input | 1 | Mask byte write strobe |
| wr_idx | input | 2 | Mask byte index |
| wr_data | input | 8 | Mask byte value |
| alt_req | input | 1 | Requested interpretation, 1 = signaling-source select |
| sig_pin_sel | input | 1 | Use the dedicated signaling input instead of serial data |
| slot_o | output | 5 | Current timeslot, 0 = channel 1 |
| bit_o | output | 3 | Bit position within the timeslot |
| alt_o | output | 1 | Active interpretation |
| blk_o | output | 1 | Blocking strobe for the current timeslot |
| sel_vec_o | output | 32 | Decoded per-channel select flags |
| cur_src_o | output | 2 | Signaling source for the current channel |
| cas_warn_o | output | 1 | Channel 1 or 17 not set to internal source |

## Verification
A wrong slot or bit count shows within one bit clock as a `slot_o`/`bit_o` mismatch, and it also moves the strobe to the wrong timeslot boundary. A corrupted mask byte first appears at `sel_vec_o` in alternate mode. In normal mode it shows when the counter reaches an affected timeslot, so the check runs at least one full frame per pattern. A mode switch taken off the frame boundary shows at `alt_o` in the cycle after the request, and it also flips `blk_o` and `sel_vec_o` together.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

    typedef enum logic [1:0] {
        SRC_SERIAL   = 2'd0,
        SRC_PIN      = 2'd1,
        SRC_INTERNAL = 2'd2
    } sig_src_e;

endpackage

// File: rtl/tcb_slot_timer.sv
module tcb_slot_timer #(
    parameter int NUM_SLOTS     = 32,
    parameter int BITS_PER_SLOT = 8,
    localparam int SLOT_W       = $clog2(NUM_SLOTS),
    localparam int BIT_W        = $clog2(BITS_PER_SLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              fsync,
    input  logic              alt_req,
    output logic [SLOT_W-1:0] slot,
    output logic [BIT_W-1:0]  bitp,
    output logic              alt
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BITS_PER_SLOT - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bitp;
        logic              alt;
    } timer_t;

    timer_t st_d, st_q;
    logic   last_bit, frame_end, boundary;

    always_comb begin
        last_bit  = (st_q.bitp == LAST_BIT);
        frame_end = last_bit && (st_q.slot == LAST_SLOT);
        boundary  = bit_en && (fsync || frame_end);
        st_d      = st_q;
        if (bit_en) begin
            if (fsync) begin
                st_d.slot = '0;
                st_d.bitp = '0;
            end else if (last_bit) begin
                st_d.bitp = '0;
                st_d.slot = frame_end ? '0 : st_q.slot + 1'b1;
            end else begin
                st_d.bitp = st_q.bitp + 1'b1;
            end
        end
        if (boundary) begin
            st_d.alt = alt_req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot = st_q.slot;
    assign bitp = st_q.bitp;
    assign alt  = st_q.alt;

endmodule

// File: rtl/tcb_mask_bank.sv
module tcb_mask_bank #(
    parameter int NUM_BYTES = 4,
    parameter int BYTE_W    = 8,
    localparam int IDX_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
    localparam int FLAT_W   = NUM_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [FLAT_W-1:0] mask
);

    typedef struct packed {
        logic [NUM_BYTES-1:0][BYTE_W-1:0] bytes;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int k = 0; k < NUM_BYTES; k++) begin
            if (wr_en && (wr_idx == IDX_W'(k))) begin
                bank_d.bytes[k] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign mask = bank_q.bytes;

endmodule

// File: rtl/tcb_sel_remap.sv
module tcb_sel_remap #(
    parameter int NUM_SLOTS = 32,
    parameter int BYTE_W    = 8
) (
    input  logic [NUM_SLOTS-1:0] mask,
    output logic [NUM_SLOTS-1:0] sel
);

    localparam int HALF     = NUM_SLOTS / 2;
    localparam int PER_HALF = BYTE_W / 2;

    for (genvar c = 0; c < NUM_SLOTS; c++) begin : g_ch
        if (c < HALF) begin : g_low
            localparam int SRC = (c / PER_HALF) * BYTE_W + 2 * (c % PER_HALF);
            assign sel[c] = mask[SRC];
        end else begin : g_high
            localparam int SRC = ((c - HALF) / PER_HALF) * BYTE_W
                               + 2 * ((c - HALF) % PER_HALF) + 1;
            assign sel[c] = mask[SRC];
        end
    end

endmodule

// File: rtl/tx_chan_blk.sv
module tx_chan_blk #(
    parameter int NUM_SLOTS     = 32,
    parameter int BITS_PER_SLOT = 8,
    parameter int BYTE_W        = 8,
    localparam int NUM_BYTES    = NUM_SLOTS / BYTE_W,
    localparam int IDX_W        = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
    localparam int SLOT_W       = $clog2(NUM_SLOTS),
    localparam int BIT_W        = $clog2(BITS_PER_SLOT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic                 fsync,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [BYTE_W-1:0]    wr_data,
    input  logic                 alt_req,
    input  logic                 sig_pin_sel,
    output logic [SLOT_W-1:0]    slot_o,
    output logic [BIT_W-1:0]     bit_o,
    output logic                 alt_o,
    output logic                 blk_o,
    output logic [NUM_SLOTS-1:0] sel_vec_o,
    output logic [1:0]           cur_src_o,
    output logic                 cas_warn_o
);
    import tcb_pkg::*;

    localparam int HALF = NUM_SLOTS / 2;

    logic [NUM_SLOTS-1:0] mask;
    logic [NUM_SLOTS-1:0] sel_raw;
    logic [SLOT_W-1:0]    slot;
    logic [BIT_W-1:0]     bitp;
    logic                 alt;
    sig_src_e             src;

    tcb_slot_timer #(
        .NUM_SLOTS    (NUM_SLOTS),
        .BITS_PER_SLOT(BITS_PER_SLOT)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .fsync  (fsync),
        .alt_req(alt_req),
        .slot   (slot),
        .bitp   (bitp),
        .alt    (alt)
    );

    tcb_mask_bank #(
        .NUM_BYTES(NUM_BYTES),
        .BYTE_W   (BYTE_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .mask   (mask)
    );

    tcb_sel_remap #(
        .NUM_SLOTS(NUM_SLOTS),
        .BYTE_W   (BYTE_W)
    ) u_remap (
        .mask(mask),
        .sel (sel_raw)
    );

    always_comb begin
        if (!alt) begin
            src = SRC_SERIAL;
        end else if (sel_raw[slot]) begin
            src = SRC_INTERNAL;
        end else if (sig_pin_sel) begin
            src = SRC_PIN;
        end else begin
            src = SRC_SERIAL;
        end
    end

    assign slot_o     = slot;
    assign bit_o      = bitp;
    assign alt_o      = alt;
    assign blk_o      = !alt && mask[slot];
    assign sel_vec_o  = alt ? sel_raw : '0;
    assign cur_src_o  = src;
    assign cas_warn_o = alt && !(sel_raw[0] && sel_raw[HALF]);

endmodule

// File: rtl/tcb_chk.sv
module tcb_chk #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_W    = 5,
    parameter int BIT_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bit_en,
    input logic                 fsync,
    input logic [SLOT_W-1:0]    slot_o,
    input logic [BIT_W-1:0]     bit_o,
    input logic                 alt_o,
    input logic                 blk_o,
    input logic [NUM_SLOTS-1:0] sel_vec_o,
    input logic [1:0]           cur_src_o,
    input logic                 cas_warn_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
    localparam logic [BIT_W-1:0]  LAST_BIT  = '1;

    // R2
    sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && fsync) |=> (slot_o == '0 && bit_o == '0));

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(slot_o) && $stable(bit_o)));

    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !fsync && slot_o == LAST_SLOT && bit_o == LAST_BIT) |=> (slot_o == '0));

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_en && (fsync || (slot_o == LAST_SLOT && bit_o == LAST_BIT))) |=> $stable(alt_o));

    // R5
    alt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alt_o |-> !blk_o);

    // R10
    norm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_o |-> (sel_vec_o == '0 && cur_src_o == 2'd0 && !cas_warn_o));

    // R7
    src_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_src_o != 2'd3);

endmodule

bind tx_chan_blk tcb_chk #(
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_W   (SLOT_W),
    .BIT_W    (BIT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .fsync     (fsync),
    .slot_o    (slot_o),
    .bit_o     (bit_o),
    .alt_o     (alt_o),
    .blk_o     (blk_o),
    .sel_vec_o (sel_vec_o),
    .cur_src_o (cur_src_o),
    .cas_warn_o(cas_warn_o)
);

// File: tb/tx_chan_blk_tb.sv
module tx_chan_blk_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [4:0]  slot;
        logic [2:0]  bitp;
        logic        alt;
        logic        blk;
        logic [31:0] sel;
        logic [1:0]  src;
        logic        warn;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        fsync = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [7:0]  wr_data = '0;
    logic        alt_req = 1'b0;
    logic        sig_pin_sel = 1'b0;
    logic [4:0]  slot_o;
    logic [2:0]  bit_o;
    logic        alt_o;
    logic        blk_o;
    logic [31:0] sel_vec_o;
    logic [1:0]  cur_src_o;
    logic        cas_warn_o;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t q[$];

    logic [7:0] m_byte [4];
    logic [4:0] m_slot;
    logic [2:0] m_bit;
    logic       m_alt;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_chan_blk u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .alt_req(alt_req), .sig_pin_sel(sig_pin_sel),
        .slot_o(slot_o), .bit_o(bit_o), .alt_o(alt_o), .blk_o(blk_o),
        .sel_vec_o(sel_vec_o), .cur_src_o(cur_src_o), .cas_warn_o(cas_warn_o)
    );

    function automatic exp_t predict();
        exp_t e;
        logic [31:0] s;
        e.slot = m_slot;
        e.bitp = m_bit;
        e.alt  = m_alt;
        s = '0;
        // R6: byte r bit b serves channel index (b odd ? 16 : 0) + 4r + b/2
        for (int r = 0; r < 4; r++) begin
            for (int b = 0; b < 8; b++) begin
                s[(b % 2) * 16 + r * 4 + b / 2] = m_byte[r][b];
            end
        end
        if (m_alt) begin
            e.blk  = 1'b0;                                   // R5
            e.sel  = s;                                      // R6
            e.src  = s[m_slot] ? 2'd2 : (sig_pin_sel ? 2'd1 : 2'd0); // R7
            e.warn = !(s[0] && s[16]);                       // R8
        end else begin
            e.blk  = m_byte[m_slot / 8][m_slot % 8];         // R4
            e.sel  = '0;                                     // R10
            e.src  = 2'd0;
            e.warn = 1'b0;
        end
        return e;
    endfunction

    task automatic model_edge();
        logic bnd;
        bnd = bit_en && (fsync || (m_slot == 5'd31 && m_bit == 3'd7));
        if (wr_en) m_byte[wr_idx] = wr_data;                 // R3
        if (bit_en) begin                                    // R2
            if (fsync) begin
                m_slot = '0; m_bit = '0;
            end else if (m_bit == 3'd7) begin
                m_bit = '0; m_slot = m_slot + 1'b1;
            end else begin
                m_bit = m_bit + 1'b1;
            end
        end
        if (bnd) m_alt = alt_req;                            // R9
    endtask

    task automatic step(input logic be, input logic fs);
        bit_en = be;
        fsync  = fs;
        @(posedge clk);
        #1;
        model_edge();
        wr_en = 1'b0;
        q.push_back(predict());
    endtask

    task automatic write_byte(input logic [1:0] i, input logic [7:0] d);
        wr_en = 1'b1; wr_idx = i; wr_data = d;
        step(1'b1, 1'b0);
    endtask

    task automatic run(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            step((gap == 0) || (i % gap != 0), 1'b0);
        end
    endtask

    task automatic fail(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_bad++;
        $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    endtask

    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (slot_o != e.slot || bit_o != e.bitp) fail("R2", "slot/bit", {24'd0, slot_o, bit_o}, {24'd0, e.slot, e.bitp});
            if (alt_o != e.alt) fail("R9", "alt_o", 32'(alt_o), 32'(e.alt));
            if (blk_o != e.blk) fail(e.alt ? "R5" : "R4", "blk_o", 32'(blk_o), 32'(e.blk));
            if (sel_vec_o != e.sel) fail(e.alt ? "R6" : "R10", "sel_vec_o", sel_vec_o, e.sel);
            if (cur_src_o != e.src) fail("R7", "cur_src_o", 32'(cur_src_o), 32'(e.src));
            if (cas_warn_o != e.warn) fail("R8", "cas_warn_o", 32'(cas_warn_o), 32'(e.warn));
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_byte[i] = '0;
        m_slot = '0; m_bit = '0; m_alt = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: state after reset, all zero
        q.push_back(predict());
        @(negedge clk);
        // R3 / R4: linear pattern in normal mode
        write_byte(2'd0, 8'hA5);
        write_byte(2'd1, 8'h3C);
        write_byte(2'd2, 8'h0F);
        write_byte(2'd3, 8'h81);
        step(1'b1, 1'b1);
        run(300, 0);
        // R2: idle bit clocks hold the counter
        run(200, 3);
        // R9: request mid-frame, taken only at boundary
        alt_req = 1'b1;
        run(40, 0);
        step(1'b1, 1'b1);
        // R5 R6 R7 R8: alternate mode, warn set then cleared
        run(100, 0);
        sig_pin_sel = 1'b1;
        run(80, 0);
        write_byte(2'd0, 8'h03);
        run(30, 0);
        write_byte(2'd2, 8'hAA);
        write_byte(2'd3, 8'h55);
        sig_pin_sel = 1'b0;
        run(300, 0);
        // R9: fsync without bit_en does not move mode, natural wrap does
        alt_req = 1'b0;
        step(1'b0, 1'b1);
        run(300, 0);
        // R10 back in normal mode, then byte rewrite
        write_byte(2'd1, 8'hFF);
        step(1'b1, 1'b1);
        run(260, 4);
        repeat (2) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 50000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule